// File: doc/BRIEF.md
# IO Page-Directory Address Translator

This block turns DMA addresses that arrive from an IO bus into physical memory addresses. It works in 4 KiB pages. Each request address first loses its low 12 bits. The page is then compared against a window set by a base register and a mask register. Bit 0 of the base register switches that window on or off.

A page inside an enabled window needs a directory lookup. The block computes the address of a 64-bit directory entry from a configurable directory pointer and the page number, and issues a single read on its memory port. When the entry returns, its top bit says whether the entry is valid:
- A valid entry gives the translated page address, with read/write permission.
- An invalid entry gives a fault: zero address and no permission.

A page outside the window, or any page while the window is disabled, skips the table. It goes through a fixed default mapping and is answered in the next cycle.

Software programs the base, mask and directory pointer through a write-only configuration port with 64-bit writes. Only one translation is in flight at a time, and the request port reports when it can take a new one.

Top module: `iopdir_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. All three configuration registers are zero, so the window is disabled.
- R2: While bit 0 of the base register is 0, no request raises `mem_req`.
- R3: A page p is in the window when base bit 0 is 1 and (p AND mask) equals the base with bit 0 cleared. A page in the window raises `mem_req` one cycle after acceptance. Any other page is answered with `rsp_valid` one cycle after acceptance, with `rsp_ok` = 1.
- R4: `mem_addr` equals the directory pointer plus (p shifted right by 12) times 8.
- R5: A returned entry with bit 63 set is answered with `rsp_ok` = 1. The address is the entry with bit 63 and bits 11:0 cleared.
- R6: A returned entry with bit 63 clear is answered with `rsp_ok` = 0 and `rsp_addr` = 0.
- R7: Default mapping for a page that is not looked up:
  - A page below 2^32 whose bits 31:28 are all ones gets bits 63:32 set to ones.
  - Every other page is returned unchanged.
  - Bits 11:0 of the result are always 0.
- R8: Register offsets on the configuration port:
  - Base register: 0x300.
  - Mask register: 0x308.
  - Directory pointer: 0x320.
  - Setting `cfg_addr` bit 17 selects the same register (alias).
  - Writes to 0x310, 0x318 or any other offset change nothing.
- R9: From the acceptance of a lookup until its response, `req_ready` is 0. A request presented during that time is ignored and produces no response.
- R10: A configuration write in the same cycle as an accepted request does not affect that request. The write takes effect for the next request.
- R11: A lookup response appears one cycle after `mem_rvalid` is sampled while waiting. Each accepted request gives exactly one `rsp_valid` pulse. `mem_rvalid` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 18 | Configuration byte offset |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 64 | DMA address to translate |
| req_ready | output | 1 | Block can accept a request |
| mem_req | output | 1 | One-cycle directory-entry read strobe |
| mem_addr | output | 64 | Byte address of the directory entry |
| mem_rvalid | input | 1 | Directory entry data valid |
| mem_rdata | input | 64 | Directory entry |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 64 | Translated page address |
| rsp_ok | output | 1 | 1 = read/write permitted, 0 = fault |

## Verification
Two things can coincide: a configuration write and the acceptance of a request. The bench provokes this by driving `cfg_we` and `req_valid` in the same cycle, with the write disabling the window. The request is judged correct if it still issues the directory read under the old base. The next request, sent with the same address, must then pass through untranslated.

A second overlap is a new request held high while a lookup waits for memory. The bench expects exactly one response, carrying the translated page of the first request.

// File: rtl/iopdir_pkg.sv
package iopdir_pkg;

    localparam int unsigned ADDR_W     = 64;
    localparam int unsigned LOW_W      = 32;
    localparam int unsigned SEXT_W     = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t VALID_BIT = addr_t'(1) << (ADDR_W - 1);

    localparam logic [11:0] OFS_BASE = 12'h300;
    localparam logic [11:0] OFS_MASK = 12'h308;
    localparam logic [11:0] OFS_DIR  = 12'h320;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xl_state_e;

    typedef struct packed {
        addr_t base;
        addr_t mask;
        addr_t dir;
    } cfg_regs_t;

    typedef struct packed {
        xl_state_e st;
        logic      mem_req;
        addr_t     mem_addr;
        logic      rsp_valid;
        addr_t     rsp_addr;
        logic      rsp_ok;
    } xl_regs_t;

endpackage

// File: rtl/iopdir_cfg_regs.sv
module iopdir_cfg_regs
    import iopdir_pkg::*;
#(
    parameter int unsigned CFG_AW    = 18,
    parameter int unsigned ALIAS_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  addr_t             cfg_wdata,
    output addr_t             base_q,
    output addr_t             mask_q,
    output addr_t             dir_q
);

    localparam logic [CFG_AW-1:0] ALIAS_CLR = ~(CFG_AW'(1) << ALIAS_BIT);
    localparam logic [CFG_AW-1:0] A_BASE    = CFG_AW'(OFS_BASE);
    localparam logic [CFG_AW-1:0] A_MASK    = CFG_AW'(OFS_MASK);
    localparam logic [CFG_AW-1:0] A_DIR     = CFG_AW'(OFS_DIR);

    cfg_regs_t         r_d, r_q;
    logic [CFG_AW-1:0] ofs;

    assign ofs = cfg_addr & ALIAS_CLR;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            if (ofs == A_BASE) r_d.base = cfg_wdata;
            if (ofs == A_MASK) r_d.mask = cfg_wdata;
            if (ofs == A_DIR)  r_d.dir  = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_q = r_q.base;
    assign mask_q = r_q.mask;
    assign dir_q  = r_q.dir;

endmodule

// File: rtl/iopdir_window.sv
module iopdir_window
    import iopdir_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT  = 12,
    parameter int unsigned ENTRY_SHIFT = 3
) (
    input  addr_t req_addr,
    input  addr_t base,
    input  addr_t mask,
    input  addr_t dir,
    output logic  win_hit,
    output addr_t entry_addr,
    output addr_t default_addr
);

    localparam addr_t PAGE_KEEP = ~((addr_t'(1) << PAGE_SHIFT) - addr_t'(1));
    localparam addr_t EN_CLR    = ~addr_t'(1);

    addr_t page;
    logic  below_4g;
    logic  top_region;

    assign page       = req_addr & PAGE_KEEP;
    assign win_hit    = base[0] && ((page & mask) == (base & EN_CLR));
    assign entry_addr = dir + ((page >> PAGE_SHIFT) << ENTRY_SHIFT);

    assign below_4g   = (page[ADDR_W-1:LOW_W] == '0);
    assign top_region = &page[LOW_W-1:LOW_W-SEXT_W];

    always_comb begin
        if (below_4g && top_region)
            default_addr = {{(ADDR_W-LOW_W){1'b1}}, page[LOW_W-1:0]};
        else
            default_addr = page;
    end

endmodule

// File: rtl/iopdir_xlate.sv
module iopdir_xlate
    import iopdir_pkg::*;
#(
    parameter int unsigned CFG_AW      = 18,
    parameter int unsigned ALIAS_BIT   = 17,
    parameter int unsigned PAGE_SHIFT  = 12,
    parameter int unsigned ENTRY_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              req_ready,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_addr,
    output logic              rsp_ok
);

    localparam addr_t LOW_MASK   = (addr_t'(1) << PAGE_SHIFT) - addr_t'(1);
    localparam addr_t ENTRY_KEEP = ~(VALID_BIT | LOW_MASK);

    addr_t    base_q, mask_q, dir_q;
    logic     win_hit;
    addr_t    entry_addr, default_addr;
    xl_regs_t x_d, x_q;

    iopdir_cfg_regs #(
        .CFG_AW    (CFG_AW),
        .ALIAS_BIT (ALIAS_BIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .dir_q     (dir_q)
    );

    iopdir_window #(
        .PAGE_SHIFT  (PAGE_SHIFT),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_win (
        .req_addr     (req_addr),
        .base         (base_q),
        .mask         (mask_q),
        .dir          (dir_q),
        .win_hit      (win_hit),
        .entry_addr   (entry_addr),
        .default_addr (default_addr)
    );

    always_comb begin
        x_d           = x_q;
        x_d.mem_req   = 1'b0;
        x_d.rsp_valid = 1'b0;
        unique case (x_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (win_hit) begin
                        x_d.st       = ST_WAIT;
                        x_d.mem_req  = 1'b1;
                        x_d.mem_addr = entry_addr;
                    end else begin
                        x_d.rsp_valid = 1'b1;
                        x_d.rsp_addr  = default_addr;
                        x_d.rsp_ok    = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    x_d.st        = ST_IDLE;
                    x_d.rsp_valid = 1'b1;
                    if ((mem_rdata & VALID_BIT) != '0) begin
                        x_d.rsp_addr = mem_rdata & ENTRY_KEEP;
                        x_d.rsp_ok   = 1'b1;
                    end else begin
                        x_d.rsp_addr = '0;
                        x_d.rsp_ok   = 1'b0;
                    end
                end
            end
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign req_ready = (x_q.st == ST_IDLE);
    assign mem_req   = x_q.mem_req;
    assign mem_addr  = x_q.mem_addr;
    assign rsp_valid = x_q.rsp_valid;
    assign rsp_addr  = x_q.rsp_addr;
    assign rsp_ok    = x_q.rsp_ok;

endmodule

// File: rtl/iopdir_xlate_chk.sv
module iopdir_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        win_hit,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic        rsp_ok,
    input logic [63:0] rsp_addr
);

    a_r3_hit_fetches: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && win_hit) |=> (mem_req && !rsp_valid));

    a_r3_miss_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !win_hit) |=> (rsp_valid && rsp_ok && !mem_req));

    a_r9_busy_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r11_rsp_after_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && mem_rvalid) |=> (rsp_valid && req_ready));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, mem_req}));

    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_addr == 64'h0));

    a_r7_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr[11:0] == 12'h000));

endmodule

bind iopdir_xlate iopdir_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .win_hit    (win_hit),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_addr   (rsp_addr)
);

// File: tb/iopdir_xlate_test.sv
module iopdir_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [17:0] cfg_addr;
    logic [63:0] cfg_wdata;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        req_ready;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_ok;

    always #10 clk = ~clk;

    iopdir_xlate uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_addr   (rsp_addr),
        .rsp_ok     (rsp_ok)
    );

    typedef struct packed {
        logic [63:0] base;
        logic [63:0] mask;
        logic [63:0] dir;
        logic [63:0] addr;
        logic [63:0] entry;
        logic [63:0] exp_addr;
        logic [63:0] exp_ent;
        logic        lookup;
        logic        ok;
        logic        use_alias;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 64'h0, 64'h0, 64'h1234_5678, 64'h0,
          64'h1234_5000, 64'h0, 1'b0, 1'b1, 1'b0},
        '{64'h0, 64'h0, 64'h0, 64'hF123_4ABC, 64'h0,
          64'hFFFF_FFFF_F123_4000, 64'h0, 1'b0, 1'b1, 1'b1},
        '{64'h0, 64'h0, 64'h0, 64'h12_3456_7FFF, 64'h0,
          64'h12_3456_7000, 64'h0, 1'b0, 1'b1, 1'b0},
        '{64'h8000_0001, 64'hFFFF_FFFF_F000_0000, 64'h10_0000, 64'h8000_5123,
          64'h8000_0012_3456_7ABC, 64'h12_3456_7000, 64'h50_0028, 1'b1, 1'b1, 1'b0},
        '{64'h8000_0001, 64'hFFFF_FFFF_F000_0000, 64'h10_0000, 64'h8000_5123,
          64'h0000_0000_AAAA_B000, 64'h0, 64'h50_0028, 1'b1, 1'b0, 1'b1},
        '{64'h8000_0001, 64'hFFFF_FFFF_F000_0000, 64'h10_0000, 64'h9000_0000,
          64'h0, 64'h9000_0000, 64'h0, 1'b0, 1'b1, 1'b0},
        '{64'h8000_0000, 64'hFFFF_FFFF_F000_0000, 64'h10_0000, 64'h8000_5123,
          64'h0, 64'h8000_5000, 64'h0, 1'b0, 1'b1, 1'b1},
        '{64'h1, 64'h0, 64'h2000, 64'hFFF,
          64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_F000, 64'h2000, 1'b1, 1'b1, 1'b0},
        '{64'h40_0000_0001, 64'hFFFF_FFC0_0000_0000, 64'h1000_0000, 64'h40_0000_3000,
          64'h8000_0000_0000_0000, 64'h0, 64'h3000_0018, 1'b1, 1'b1, 1'b1}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R8: one full-width register write; alias picks bit 17
    task automatic cfg_write(logic [11:0] ofs, logic [63:0] d, bit alias_sel);
        cfg_we    = 1'b1;
        cfg_addr  = {alias_sel, 5'b0, ofs};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Called at a negedge; returns at a negedge.
    task automatic run_req(logic [63:0] a, bit lookup, logic [63:0] ent,
                           logic [63:0] entry, logic [63:0] exp_a, bit exp_ok,
                           string tag);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (lookup) begin
            check64({tag, " R3 lookup issued"}, {63'b0, mem_req}, 64'h1);
            check64({tag, " R4 entry address"}, mem_addr, ent);
            check64({tag, " R9 busy"}, {63'b0, req_ready}, 64'h0);
            @(negedge clk);
            check64({tag, " R11 single strobe"}, {63'b0, mem_req}, 64'h0);
            mem_rvalid = 1'b1;
            mem_rdata  = entry;
            @(negedge clk);
            mem_rvalid = 1'b0;
            check64({tag, " R11 response"}, {63'b0, rsp_valid}, 64'h1);
            check64({tag, exp_ok ? " R5 address" : " R6 address"}, rsp_addr, exp_a);
            check64({tag, exp_ok ? " R5 ok" : " R6 fault"}, {63'b0, rsp_ok},
                    {63'b0, exp_ok});
        end else begin
            check64({tag, " R2 no fetch"}, {63'b0, mem_req}, 64'h0);
            check64({tag, " R3 next-cycle response"}, {63'b0, rsp_valid}, 64'h1);
            check64({tag, " R7 mapped address"}, rsp_addr, exp_a);
            check64({tag, " R7 ok"}, {63'b0, rsp_ok}, 64'h1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_addr   = '0;
        cfg_wdata  = '0;
        req_valid  = 1'b0;
        req_addr   = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, and registers cleared (window disabled)
        check64("R1 req_ready", {63'b0, req_ready}, 64'h1);
        check64("R1 rsp_valid", {63'b0, rsp_valid}, 64'h0);
        check64("R1 mem_req", {63'b0, mem_req}, 64'h0);
        run_req(64'hF000_0000, 1'b0, 64'h0, 64'h0, 64'hFFFF_FFFF_F000_0000, 1'b1, "R1");

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            cfg_write(12'h300, VECS[i].base, VECS[i].use_alias);
            cfg_write(12'h308, VECS[i].mask, VECS[i].use_alias);
            cfg_write(12'h320, VECS[i].dir,  VECS[i].use_alias);
            run_req(VECS[i].addr, VECS[i].lookup, VECS[i].exp_ent, VECS[i].entry,
                    VECS[i].exp_addr, VECS[i].ok, $sformatf("vec%0d", i));
        end

        // R8: writes to unused offsets leave the window intact
        cfg_write(12'h300, 64'h8000_0001, 1'b0);
        cfg_write(12'h308, 64'hFFFF_FFFF_F000_0000, 1'b0);
        cfg_write(12'h320, 64'h10_0000, 1'b0);
        cfg_write(12'h310, 64'h0, 1'b0);
        cfg_write(12'h318, 64'h0, 1'b1);
        cfg_write(12'h328, 64'h0, 1'b0);
        cfg_write(12'h304, 64'h0, 1'b0);
        run_req(64'h8000_5123, 1'b1, 64'h50_0028, 64'h8000_0000_0000_7000,
                64'h7000, 1'b1, "R8 ignored offsets");

        // R10: config write coinciding with request acceptance
        cfg_we    = 1'b1;
        cfg_addr  = 18'h00300;
        cfg_wdata = 64'h0;
        req_valid = 1'b1;
        req_addr  = 64'h8000_5123;
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
        check64("R10 old base used", {63'b0, mem_req}, 64'h1);
        check64("R10 entry address", mem_addr, 64'h50_0028);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = 64'h8000_0000_0000_9000;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check64("R10 response", rsp_addr, 64'h9000);
        run_req(64'h8000_5123, 1'b0, 64'h0, 64'h0, 64'h8000_5000, 1'b1, "R10 new base");

        // R9: request held during a lookup is ignored
        cfg_write(12'h300, 64'h8000_0001, 1'b1);
        req_valid = 1'b1;
        req_addr  = 64'h8000_5123;
        @(negedge clk);
        req_addr  = 64'h1000;
        check64("R9 fetch started", {63'b0, mem_req}, 64'h1);
        check64("R9 ready low", {63'b0, req_ready}, 64'h0);
        @(negedge clk);
        check64("R9 no response to held request", {63'b0, rsp_valid}, 64'h0);
        mem_rvalid = 1'b1;
        mem_rdata  = 64'h8000_0000_0ABC_D000;
        req_valid  = 1'b0;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check64("R9 single response", {63'b0, rsp_valid}, 64'h1);
        check64("R9 response address", rsp_addr, 64'h0ABC_D000);
        @(negedge clk);
        check64("R9 no extra response", {63'b0, rsp_valid}, 64'h0);
        check64("R9 no extra fetch", {63'b0, mem_req}, 64'h0);

        // R11: stray read data while idle is ignored
        mem_rvalid = 1'b1;
        mem_rdata  = 64'h8000_0000_0000_1000;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check64("R11 idle rvalid ignored", {63'b0, rsp_valid}, 64'h0);
        check64("R11 still ready", {63'b0, req_ready}, 64'h1);

        finish_run();
    end

endmodule